// File: doc/BRIEF.md
# Five-Level Level-Shifted Carrier Gate Modulator

This block drives the six gates of a single-phase five-level bridge. The bridge has three legs. Each leg has an upper and a lower switch. Two of the legs switch at carrier rate. The third leg switches only when the reference changes sign. The block produces the five bridge levels 0, ±Vs and ±2Vs.

A phase accumulator and a quarter-wave sine table produce the reference. The modulation index scales it, and its magnitude is compared against two identical triangular carriers. One carrier sits a full carrier amplitude above the other, so the pair spans the reference magnitude range with no overlap. The number of carriers the magnitude exceeds sets how many fast legs point "against" the line leg. The sign of the reference picks the line leg's state.

The ±Vs level can be produced by either fast leg. The block alternates between the two on successive ±Vs pulses. Every leg has a programmable dead band. A low enable or a high fault input clears all gates on the next clock edge, and the gates stay low until the hold is released.

Top module: `pd5_modulator`

## Requirements
- R1: Gate bits are gate_o[0] = fast leg X upper, [1] = X lower, [2] = line leg upper, [3] = line leg lower, [4] = fast leg Y upper, [5] = Y lower. level_o is a signed 3-bit two's-complement code. It is computed from the gate state: if [2] is high, level_o = gate_o[1] + gate_o[5]; else if [3] is high, level_o = −(gate_o[0] + gate_o[4]); otherwise level_o = 0. In a run with a large modulation index, all five values −2..+2 appear.
- R2: The phase advances by ref_step_i each clock, starting from 0 at reset, over 2^24 counts per line period. Whenever each leg has exactly one gate on, level_o lies between floor(x) and ceil(x), where x = 2·(mod_index_i/256)·sin(2π·phase/2^24). A small tolerance is allowed for table quantization.
- R3: The upper and lower gates of one leg are never high together.
- R4: When a gate turns on, both gates of its leg have been low for at least dead_i consecutive clock cycles.
- R5: After a clock edge that samples enable_i low or fault_i high, all six gates are low.
- R6: The gates stay low for as long as the hold lasts. After release, no gate turns on within the first dead_i+1 clock cycles.
- R7: The line-leg upper gate is on during the positive half of the reference, and the lower gate during the negative half. Each of the two rises exactly once and falls exactly once per line period.
- R8: Each time the settled level enters +1 or −1, the fast leg that carries it is the other one from the previous entry.
- R9: With mod_index_i = 0, level_o stays 0.
- R10: During and right after reset, gate_o = 0 and level_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Run permission; low forces all gates off |
| fault_i | input | 1 | Fault hold; high forces all gates off |
| ref_step_i | input | 24 | Reference phase increment per clock |
| car_div_i | input | 16 | Carrier count advances every car_div_i+1 clocks |
| mod_index_i | input | 8 | Reference amplitude, mod_index_i/256 of full scale |
| dead_i | input | 8 | Dead band in clock cycles |
| gate_o | output | 6 | Gate drives, bit map in R1 |
| level_o | output | 3 | Signed level implied by the gates |

## Verification
The hardest situation to reach is the choice between the two redundant ±Vs combinations. With a moving reference, the ±1 pulses are short near level boundaries, and they are hidden by dead bands. The stimulus therefore first steps the phase to exactly a quarter or three quarters of a period, using a large increment for a counted number of clocks. It then sets the increment to zero, which freezes the reference at its positive or negative crest. At modulation indices of 3/8 and 3/4, the level then pulses regularly between 0 and ±1, or between ±1 and ±2. This exposes many ±1 entries whose fast-leg choice can be compared one after another.

// File: rtl/pd5_pkg.sv
// Shared types for the five-level modulator.
// Assumes three legs: two fast legs and one line-frequency leg.
package pd5_pkg;
    // Which switch of a leg is driven
    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_t;

    localparam int NUM_LEGS = 3;
    localparam int LEG_X    = 0;
    localparam int LEG_LINE = 1;
    localparam int LEG_Y    = 2;
endpackage

// File: rtl/pd5_sine_ref.sv
// Reference generator: a phase accumulator addresses a quarter-wave sine
// table that is computed at elaboration. The result is scaled by the
// modulation index into carrier count units, so full scale is 2*CAR_MAX.
// Assumes mod index / 2^MI_W is the amplitude fraction.
module pd5_sine_ref #(
    parameter int PHASE_W = 24,
    parameter int LUT_AW  = 6,
    parameter int LUT_W   = 16,
    parameter int MI_W    = 8,
    parameter int CAR_MAX = 255,
    parameter int MAG_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] step_i,
    input  logic [MI_W-1:0]    mod_index_i,
    output logic [MAG_W-1:0]   mag_o,
    output logic               neg_o
);
    localparam int  QN      = 1 << LUT_AW;
    localparam int  TOP_W   = LUT_AW + 2;
    localparam int  SHIFT   = PHASE_W - TOP_W;
    localparam int  PROD_W  = LUT_W + MI_W + MAG_W;
    localparam int  LUT_MAX = (1 << LUT_W) - 1;
    localparam real PI_R    = 3.141592653589793;

    logic [LUT_W-1:0]   lut [QN];
    logic [PHASE_W-1:0] phase_q;
    logic [TOP_W-1:0]   top_bits;
    logic [LUT_AW-1:0]  idx;
    logic [PROD_W-1:0]  prod;

    // Table entries sampled at the centre of each quarter-wave step
    for (genvar i = 0; i < QN; i++) begin : g_lut
        localparam real ANGLE = (real'(i) + 0.5) * PI_R / (2.0 * real'(QN));
        localparam int  CODE  = $rtoi($sin(ANGLE) * real'(LUT_MAX) + 0.5);
        assign lut[i] = LUT_W'(CODE);
    end

    // Phase accumulation, one step per clock
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + step_i;
    end

    // Quadrant folding and amplitude scaling
    always_comb begin
        top_bits = TOP_W'(phase_q >> SHIFT);
        idx      = top_bits[TOP_W-2] ? ~top_bits[LUT_AW-1:0] : top_bits[LUT_AW-1:0];
        prod     = PROD_W'(lut[idx]) * PROD_W'(mod_index_i) * PROD_W'(2 * CAR_MAX);
    end

    // Register magnitude and half-wave sign
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_o <= '0;
            neg_o <= 1'b0;
        end else begin
            mag_o <= MAG_W'(prod >> (LUT_W + MI_W));
            neg_o <= top_bits[TOP_W-1];
        end
    end

    AST_MAG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mag_o <= MAG_W'(2 * CAR_MAX)); // R2
endmodule

// File: rtl/pd5_carrier.sv
// Triangular carrier: an up/down counter over 0..CAR_MAX that steps once
// every div_i+1 clocks. The upper carrier is this value plus CAR_MAX, so
// both carriers share one phase. Assumes CAR_MAX >= 2.
module pd5_carrier #(
    parameter int CAR_MAX = 255,
    parameter int CAR_W   = 8,
    parameter int DIV_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic [CAR_W-1:0] car_o
);
    logic [DIV_W-1:0] div_q;
    logic             up_q;

    // Prescaler and triangle counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            car_o <= '0;
            up_q  <= 1'b1;
        end else if (div_q >= div_i) begin
            div_q <= '0;
            if (up_q) begin
                car_o <= car_o + CAR_W'(1);
                if (car_o + CAR_W'(1) == CAR_W'(CAR_MAX)) up_q <= 1'b0;
            end else begin
                car_o <= car_o - CAR_W'(1);
                if (car_o == CAR_W'(1)) up_q <= 1'b1;
            end
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    AST_CARRIER_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        car_o <= CAR_W'(CAR_MAX)); // R2
    AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (car_o == $past(car_o)) || (car_o == $past(car_o) + CAR_W'(1))
        || (car_o + CAR_W'(1) == $past(car_o))); // R2
endmodule

// File: rtl/pd5_level_map.sv
// Comparator stage and switch-state mapping. The reference magnitude is
// compared with the lower and upper carriers; the count of carriers
// exceeded (0..2) and the sign set the wanted state of every leg. Each
// entry into count 1 swaps which fast leg carries the single level.
module pd5_level_map
    import pd5_pkg::*;
#(
    parameter int CAR_MAX = 255,
    parameter int CAR_W   = 8,
    parameter int MAG_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             neg_i,
    input  logic [CAR_W-1:0] car_i,
    output leg_t             want_x_o,
    output leg_t             want_line_o,
    output leg_t             want_y_o
);
    logic       lo_hit, hi_hit;
    logic [1:0] count_d, count_q;
    logic       neg_q, sel_q;
    logic       x_alt, y_alt;

    // Two comparators against the stacked carriers
    always_comb begin
        lo_hit  = mag_i > MAG_W'(car_i);
        hi_hit  = mag_i > (MAG_W'(car_i) + MAG_W'(CAR_MAX));
        count_d = 2'(lo_hit) + 2'(hi_hit);
    end

    // Register count and sign, swap the redundant choice on each entry into one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            neg_q   <= 1'b0;
            sel_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            neg_q   <= neg_i;
            if (count_d == 2'd1 && count_q != 2'd1) sel_q <= ~sel_q;
        end
    end

    // Leg states: fast legs point against the line leg per counted level
    always_comb begin
        x_alt       = (count_q == 2'd2) || (count_q == 2'd1 && !sel_q);
        y_alt       = (count_q == 2'd2) || (count_q == 2'd1 &&  sel_q);
        want_line_o = neg_q ? LEG_LO : LEG_HI;
        if (neg_q) begin
            want_x_o = x_alt ? LEG_HI : LEG_LO;
            want_y_o = y_alt ? LEG_HI : LEG_LO;
        end else begin
            want_x_o = x_alt ? LEG_LO : LEG_HI;
            want_y_o = y_alt ? LEG_LO : LEG_HI;
        end
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count_q != 2'd3); // R1
endmodule

// File: rtl/pd5_dead_band.sv
// Per-leg dead band and halt. A change of the wanted switch first turns
// the leg fully off. The new switch is turned on once the off time has
// reached dead_i cycles. A low run_i turns the leg off at the next edge.
module pd5_dead_band
    import pd5_pkg::*;
#(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  leg_t              want_i,
    input  logic [DEAD_W-1:0] dead_i,
    output logic              hi_o,
    output logic              lo_o
);
    leg_t              cur_q;
    logic [DEAD_W-1:0] cnt_q;
    logic [DEAD_W:0]   gap_q;

    // Break-before-make sequencing of one leg
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cur_q <= LEG_OFF;
            cnt_q <= '0;
        end else if (want_i != cur_q) begin
            if (cur_q != LEG_OFF) begin
                cur_q <= LEG_OFF;
                cnt_q <= '0;
            end else if (cnt_q >= dead_i) begin
                cur_q <= want_i;
            end else begin
                cnt_q <= cnt_q + DEAD_W'(1);
            end
        end
    end

    assign hi_o = (cur_q == LEG_HI);
    assign lo_o = (cur_q == LEG_LO);

    // Off-time observer for the dead-band check
    always_ff @(posedge clk) begin
        if (!rst_n || cur_q != LEG_OFF) gap_q <= '0;
        else if (gap_q != '1)           gap_q <= gap_q + (DEAD_W+1)'(1);
    end

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q != LEG_OFF && $past(cur_q) == LEG_OFF)
        |-> ($past(gap_q) >= {1'b0, $past(dead_i)})); // R4
endmodule

// File: rtl/pd5_modulator.sv
// Top of the five-level modulator: reference, carriers, comparator mapping
// and one dead-band stage per leg. The level code is decoded from the gates
// actually driven. Assumes equal dc-bus halves.
module pd5_modulator
    import pd5_pkg::*;
#(
    parameter int PHASE_W = 24,
    parameter int LUT_AW  = 6,
    parameter int LUT_W   = 16,
    parameter int MI_W    = 8,
    parameter int CAR_MAX = 255,
    parameter int DIV_W   = 16,
    parameter int DEAD_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    input  logic                fault_i,
    input  logic [PHASE_W-1:0]  ref_step_i,
    input  logic [DIV_W-1:0]    car_div_i,
    input  logic [MI_W-1:0]     mod_index_i,
    input  logic [DEAD_W-1:0]   dead_i,
    output logic [5:0]          gate_o,
    output logic signed [2:0]   level_o
);
    localparam int CAR_W  = $clog2(CAR_MAX + 1);
    localparam int MAG_W  = $clog2(2 * CAR_MAX + 1);
    localparam int GATE_W = 2 * NUM_LEGS;

    logic [MAG_W-1:0]  mag_w;
    logic              neg_w;
    logic [CAR_W-1:0]  car_w;
    leg_t              want_w [NUM_LEGS];
    logic [GATE_W-1:0] gate_w;
    logic              run_w;
    logic [1:0]        pos_cnt, neg_cnt;
    logic signed [2:0] level_w;

    assign run_w = enable_i & ~fault_i;

    pd5_sine_ref #(
        .PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .LUT_W(LUT_W),
        .MI_W(MI_W), .CAR_MAX(CAR_MAX), .MAG_W(MAG_W)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .step_i(ref_step_i),
        .mod_index_i(mod_index_i), .mag_o(mag_w), .neg_o(neg_w)
    );

    pd5_carrier #(
        .CAR_MAX(CAR_MAX), .CAR_W(CAR_W), .DIV_W(DIV_W)
    ) u_car (
        .clk(clk), .rst_n(rst_n), .div_i(car_div_i), .car_o(car_w)
    );

    pd5_level_map #(
        .CAR_MAX(CAR_MAX), .CAR_W(CAR_W), .MAG_W(MAG_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .mag_i(mag_w), .neg_i(neg_w), .car_i(car_w),
        .want_x_o(want_w[LEG_X]), .want_line_o(want_w[LEG_LINE]),
        .want_y_o(want_w[LEG_Y])
    );

    // One dead-band stage per leg
    for (genvar p = 0; p < NUM_LEGS; p++) begin : g_leg
        pd5_dead_band #(.DEAD_W(DEAD_W)) u_db (
            .clk(clk), .rst_n(rst_n), .run_i(run_w), .want_i(want_w[p]),
            .dead_i(dead_i), .hi_o(gate_w[2*p]), .lo_o(gate_w[2*p+1])
        );
    end

    assign gate_o = gate_w;

    // Level implied by the driven gate state
    always_comb begin
        pos_cnt = 2'(gate_w[2*LEG_X+1]) + 2'(gate_w[2*LEG_Y+1]);
        neg_cnt = 2'(gate_w[2*LEG_X])   + 2'(gate_w[2*LEG_Y]);
        if (gate_w[2*LEG_LINE])        level_w = $signed({1'b0, pos_cnt});
        else if (gate_w[2*LEG_LINE+1]) level_w = -$signed({1'b0, neg_cnt});
        else                           level_w = 3'sd0;
    end

    assign level_o = level_w;

    AST_GATES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i || fault_i) |=> (gate_o == '0)); // R5
endmodule

// File: tb/tb_pd5_modulator.sv
module tb_pd5_modulator;
    localparam int PHASE_W = 24;
    localparam int DIV_W   = 16;
    localparam int MI_W    = 8;
    localparam int DEAD_W  = 8;
    localparam int LINE_T  = 20410;   // 2^24 / 822 clocks

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, fault = 1'b0;
    logic [PHASE_W-1:0] step = '0;
    logic [DIV_W-1:0]   cdiv = '0;
    logic [MI_W-1:0]    mi = '0;
    logic [DEAD_W-1:0]  dead = 8'd4;
    logic [5:0]         gate;
    logic signed [2:0]  level;

    always #4 clk = ~clk;   // 125 MHz

    pd5_modulator dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .fault_i(fault),
        .ref_step_i(step), .car_div_i(cdiv), .mod_index_i(mi), .dead_i(dead),
        .gate_o(gate), .level_o(level)
    );

    typedef struct {
        int          due;
        logic [5:0]  g;
        int          lvl;
        string       req;
    } exp_t;
    exp_t sb[$];

    int checks = 0, errors = 0, cyc = 0;
    bit armed = 0, r7_on = 0, r8_on = 0, r9_on = 0;
    int ra = 0, fa = 0, rb = 0, fb = 0;
    int seen [5];
    bit have_use = 0;
    int last_use = 0, r8_entries = 0, last_settled = 99;
    longint ph = 0;
    logic [5:0] g_prev = '0;
    int lowrun [3];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int decode(input logic [5:0] g);
        if (g[2])      return int'(g[1]) + int'(g[5]);
        else if (g[3]) return -(int'(g[0]) + int'(g[4]));
        else           return 0;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver side: queue expected gate vectors for given cycles
    task automatic expect_gates(input int after, input logic [5:0] g,
                                input int lvl, input string req);
        exp_t e;
        e.due = cyc + after; e.g = g; e.lvl = lvl; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: scoreboard pops and continuous port checks
    always @(negedge clk) begin
        bit settled;
        int lv, use_leg;
        cyc++;
        if (!rst_n) ph = 0;
        else        ph = (ph + longint'(step)) % (longint'(1) << PHASE_W);
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk(gate === e.g, e.req, "gate vector", int'(gate), int'(e.g));
            chk(int'(level) == e.lvl, e.req, "level code", int'(level), e.lvl);
        end
        if (rst_n && armed) begin
            lv = int'(level);
            chk(lv == decode(gate), "R1", "level vs gates", lv, decode(gate));
            for (int p = 0; p < 3; p++) begin
                chk(!(gate[2*p] && gate[2*p+1]), "R3", "leg overlap", p, -1);
                if ((gate[2*p] || gate[2*p+1]) && !(g_prev[2*p] || g_prev[2*p+1]))
                    chk(lowrun[p] >= int'(dead), "R4", "off time", lowrun[p], int'(dead));
            end
            settled = (gate[0] ^ gate[1]) && (gate[2] ^ gate[3]) && (gate[4] ^ gate[5]);
            if (settled) begin
                seen[lv + 2] = 1;
                if (cyc % 16 == 0) begin
                    real x;
                    int lo, hi;
                    x  = 2.0 * real'(mi) / 256.0 * $sin(2.0 * 3.141592653589793 * real'(ph) / 16777216.0);
                    lo = int'($floor(x - 0.08));
                    hi = int'($ceil(x + 0.08));
                    chk(lv >= lo && lv <= hi, "R2", "level vs reference", lv, hi);
                end
                if (r8_on && (lv == 1 || lv == -1) && last_settled != lv) begin
                    use_leg = (lv > 0) ? (gate[1] ? 0 : 1) : (gate[0] ? 0 : 1);
                    if (have_use)
                        chk(use_leg != last_use, "R8", "fast leg choice", use_leg, 1 - last_use);
                    last_use = use_leg; have_use = 1; r8_entries++;
                end
                last_settled = lv;
            end
            if (r9_on) chk(lv == 0, "R9", "level at zero index", lv, 0);
            if (r7_on) begin
                if (gate[2] && !g_prev[2]) ra++;
                if (!gate[2] && g_prev[2]) fa++;
                if (gate[3] && !g_prev[3]) rb++;
                if (!gate[3] && g_prev[3]) fb++;
            end
        end
        for (int p = 0; p < 3; p++)
            lowrun[p] = (gate[2*p] || gate[2*p+1]) ? 0 : lowrun[p] + 1;
        g_prev = gate;
    end

    task automatic r8_window(input logic [MI_W-1:0] m);
        mi = m;
        wait_cyc(20);
        have_use = 0; r8_entries = 0; r8_on = 1;
        wait_cyc(3060);
        r8_on = 0;
        chk(r8_entries >= 4, "R8", "entries seen", r8_entries, 4);
    endtask

    // Watchdog
    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < 3; p++) lowrun[p] = 0;
        for (int k = 0; k < 5; k++) seen[k] = 0;
        step = 24'd822; mi = 8'd230; cdiv = '0; dead = 8'd4;
        wait_cyc(3);
        expect_gates(1, 6'b0, 0, "R10");
        wait_cyc(3);
        rst_n = 1; enable = 1;
        wait_cyc(1);
        expect_gates(1, 6'b0, 0, "R10");
        armed = 1;
        // Moving reference over three line periods (R1, R2, R7)
        wait_cyc(LINE_T / 4);
        r7_on = 1;
        wait_cyc(3 * LINE_T);
        r7_on = 0;
        chk(ra == 3, "R7", "line upper rises", ra, 3);
        chk(fa == 3, "R7", "line upper falls", fa, 3);
        chk(rb == 3, "R7", "line lower rises", rb, 3);
        chk(fb == 3, "R7", "line lower falls", fb, 3);
        for (int k = 0; k < 5; k++)
            chk(seen[k] == 1, "R1", "level value reached", k - 2, k - 2);
        // Fault hold and release (R5, R6)
        expect_gates(2, 6'b0, 0, "R5");
        for (int k = 3; k <= 21; k++) expect_gates(k, 6'b0, 0, "R6");
        fault = 1;
        wait_cyc(21);
        fault = 0;
        for (int k = 1; k <= int'(dead) + 1; k++) expect_gates(k, 6'b0, 0, "R6");
        wait_cyc(300);
        // Enable drop (R5)
        expect_gates(2, 6'b0, 0, "R5");
        for (int k = 3; k <= 12; k++) expect_gates(k, 6'b0, 0, "R6");
        enable = 0;
        wait_cyc(12);
        enable = 1;
        wait_cyc(300);
        // Zero modulation index (R9)
        mi = 8'd0;
        wait_cyc(12);
        r9_on = 1;
        wait_cyc(LINE_T);
        r9_on = 0;
        // Frozen crest: step phase to 2^22 then to 3*2^22 (R8)
        rst_n = 0; step = '0;
        wait_cyc(3);
        rst_n = 1;
        step = 24'd65536;
        wait_cyc(64);
        step = '0;
        r8_window(8'd96);
        r8_window(8'd192);
        step = 24'd65536;
        wait_cyc(128);
        step = '0;
        r8_window(8'd96);
        r8_window(8'd192);
        wait_cyc(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule